// File: doc/BRIEF.md
# Four-Operand Carry-Save Compressor

This block takes four unsigned operands of equal width and reduces them to a redundant pair: a sum vector and a carry vector. Added with the carry weighted by two, the pair gives the total of the four operands. No carry crosses more than one bit position. The block is therefore useful as the reduction stage ahead of a single carry-propagate adder, for example in a multiplier's partial-product tree or in an accumulator that sums four values per cycle.

The reduction uses two ranks of per-bit adders. The first rank compresses the first three operands into a partial sum and a partial carry. The second rank merges the partial sum, the partial carry moved up one position, and the fourth operand. Its lowest position needs only a half adder, because no partial carry enters there. The highest partial carry has no partner, so it becomes the top bit of the sum vector. As a result the sum is one bit wider than the carry. The block is purely combinational and has no clock or reset.

Top module: `csa_compress4`

## Requirements
- R1: For every input combination, in_a + in_b + in_c + in_d equals sum_o + 2*carry_o, with all values read as unsigned integers.
- R2: Define, per bit, ps = in_a ^ in_b ^ in_c (partial sum) and pc = majority(in_a, in_b, in_c) (partial carry). Then sum_o[0] = ps[0] ^ in_d[0] and carry_o[0] = ps[0] & in_d[0], so sum_o[0] and carry_o[0] are never both 1.
- R3: For each bit i from 1 to N, sum_o[i] = ps[i] ^ pc[i-1] ^ in_d[i] and carry_o[i] = majority(ps[i], pc[i-1], in_d[i]). Each of these output bits depends only on input bits i and i-1.
- R4: The top sum bit sum_o[N+1] equals pc[N], the majority of in_a[N], in_b[N] and in_c[N].
- R5: All-zero inputs give all-zero outputs. All-ones inputs give carry_o all ones, and give sum_o with bit 0 clear and every other bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_a | input | N+1 | First operand |
| in_b | input | N+1 | Second operand |
| in_c | input | N+1 | Third operand |
| in_d | input | N+1 | Fourth operand, enters the second rank |
| sum_o | output | N+2 | Sum vector of the carry-save result |
| carry_o | output | N+1 | Carry vector, weighted by two |

## Verification
The case hardest to reach is the top position. There, a first-rank carry at bit N must appear in sum_o[N+1], while the second-rank full adder at bit N also produces a carry. Random operands set all three top bits only about one time in eight, and set them together with a full carry chain into bit N more rarely still. Directed vectors therefore cover all-ones, single high bits on three operands, and one-hot patterns at bit N. These run alongside a few thousand seeded random vectors, and every bit is checked against per-bit reference functions.

// File: rtl/csa_compress4.sv
module csa_compress4 #(
  parameter int N = 7
) (
  input  logic [N:0]   in_a,
  input  logic [N:0]   in_b,
  input  logic [N:0]   in_c,
  input  logic [N:0]   in_d,
  output logic [N+1:0] sum_o,
  output logic [N:0]   carry_o
);

  localparam int W = N + 1;

  logic [N:0] psum;
  logic [N:0] pcar;

  assign psum = in_a ^ in_b ^ in_c;
  assign pcar = (in_a & in_b) | (in_a & in_c) | (in_b & in_c);

  assign sum_o[0]   = psum[0] ^ in_d[0];
  assign carry_o[0] = psum[0] & in_d[0];

  for (genvar i = 1; i < W; i++) begin : g_rank2
    assign sum_o[i]   = psum[i] ^ pcar[i-1] ^ in_d[i];
    assign carry_o[i] = (psum[i] & pcar[i-1]) | (psum[i] & in_d[i]) | (pcar[i-1] & in_d[i]);
  end

  assign sum_o[N+1] = pcar[N];

  always_comb begin
    if (!$isunknown({in_a, in_b, in_c, in_d})) begin
      a_r1_identity: assert ({2'b00, in_a} + {2'b00, in_b} + {2'b00, in_c} + {2'b00, in_d}
                             == {1'b0, sum_o} + {1'b0, carry_o, 1'b0});
      a_r2_half_excl: assert (!(sum_o[0] && carry_o[0]));
      a_r4_top: assert (sum_o[N+1] == ($countones({in_a[N], in_b[N], in_c[N]}) >= 2));
    end
  end

  for (genvar k = 1; k < W; k++) begin : g_chk
    always_comb begin
      if (!$isunknown({in_a, in_b, in_c, in_d})) begin
        a_r3_bit_count: assert ($countones({psum[k], pcar[k-1], in_d[k]})
                                == 32'(sum_o[k]) + 2 * 32'(carry_o[k]));
      end
    end
  end

endmodule

// File: tb/sim_csa_compress4.sv
module sim_csa_compress4;
  localparam int N = 7;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N:0]   a, b, c, d;
  logic [N+1:0] s;
  logic [N:0]   cy;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  csa_compress4 #(.N(N)) u0 (
    .in_a(a), .in_b(b), .in_c(c), .in_d(d), .sum_o(s), .carry_o(cy)
  );

  function automatic logic maj(input logic p, input logic q, input logic r);
    return (p & q) | (p & r) | (q & r);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h c=%h d=%h actual=%0h expected=%0h", req, a, b, c, d, act, exp);
    end
  endtask

  task automatic apply(input logic [N:0] va, input logic [N:0] vb,
                       input logic [N:0] vc, input logic [N:0] vd);
    logic [N:0] ps, pc;
    logic [N+1:0] es;
    logic [N:0] ec;
    longint total;
    @(posedge clk);
    a = va; b = vb; c = vc; d = vd;
    @(negedge clk);
    ps = va ^ vb ^ vc;
    for (int i = 0; i <= N; i++) pc[i] = maj(va[i], vb[i], vc[i]);
    es[0] = ps[0] ^ vd[0];
    ec[0] = ps[0] & vd[0];
    for (int i = 1; i <= N; i++) begin
      es[i] = ps[i] ^ pc[i-1] ^ vd[i];
      ec[i] = maj(ps[i], pc[i-1], vd[i]);
    end
    es[N+1] = pc[N];
    total = longint'(va) + longint'(vb) + longint'(vc) + longint'(vd);
    chk("R1 identity", longint'(s) + 2 * longint'(cy), total);
    chk("R2 bit0", longint'({s[0], cy[0]}), longint'({es[0], ec[0]}));
    chk("R3 middle sum", longint'(s[N:1]), longint'(es[N:1]));
    chk("R3 middle carry", longint'(cy[N:1]), longint'(ec[N:1]));
    chk("R4 top", longint'(s[N+1]), longint'(es[N+1]));
  endtask

  localparam logic [N:0] ONES = '1;

  initial begin
    a = '0; b = '0; c = '0; d = '0;
    apply('0, '0, '0, '0);
    chk("R5 zeros sum", longint'(s), 0);
    chk("R5 zeros carry", longint'(cy), 0);
    apply(ONES, ONES, ONES, ONES);
    chk("R5 ones sum", longint'(s), longint'({1'b1, ONES[N-1:0], 1'b0}));
    chk("R5 ones carry", longint'(cy), longint'(ONES));
    apply(ONES, ONES, ONES, '0);
    apply('0, '0, '0, ONES);
    for (int i = 0; i <= N; i++) begin
      apply(ONES << i & ONES, '0, '0, '0);
      apply((N+1)'(1) << i, (N+1)'(1) << i, (N+1)'(1) << i, '0);
      apply((N+1)'(1) << i, (N+1)'(1) << i, (N+1)'(1) << i, (N+1)'(1) << i);
      apply('0, '0, '0, (N+1)'(1) << i);
      apply((N+1)'(1) << i, (N+1)'(1) << i, '0, ONES);
    end
    void'($urandom(32'd4242));
    for (int k = 0; k < 3000; k++) begin
      apply((N+1)'($urandom), (N+1)'($urandom), (N+1)'($urandom), (N+1)'($urandom));
    end
    for (int k = 0; k < 500; k++) begin
      logic [N:0] r = (N+1)'($urandom);
      apply(r | ((N+1)'(1) << N), ONES, r ^ ONES, (N+1)'($urandom));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule